// File: doc/BRIEF.md
# Indexed Configuration Register Bank

This block is a bank of byte-wide chipset configuration registers on an 8-bit I/O bus. Software first writes a register number to an index port, then makes exactly one access to a data port to read or write that register. To make another access, it writes the index again. A few further control bytes sit at their own I/O addresses and need no index.

Each indexed register keeps only the bits its write mask allows. Several registers drive control outputs:
- four registers together form a 32-bit replacement NMI vector;
- one bit of a separate register enables that vector;
- one register holds the expanded-memory configuration byte, which is exported together with a strobe that marks each write to it.

A guarded software reset request comes from one of the direct control ports. It pulses an output for one cycle, and the whole register file returns to its power-up state on the following clock edge.

Top module: `cfg_regfile`

## Requirements
- R1: A write to the index port (0x22) stores the byte as the current index and sets the access flag. A read of the index port returns the current index.
- R2: A read or write of the data port (0x23) acts on the indexed register only while the access flag is set, and every data-port access clears the flag. With the flag clear, a data read returns 0xFF and a data write changes nothing.
- R3: Data writes keep only the bits allowed by the register's mask: 0xC7 for index 0x40, 0xED for 0x41, 0x01 for 0x42, and all eight bits for 0x43 to 0x49, 0x4B and 0x4C.
- R4: Only indices 0x40 to 0x49, 0x4B and 0x4C exist. Any other index (for example 0x4A or 0x50) reads 0xFF, and writing it alters no register.
- R5: `nmi_vector` is {reg 0x47, reg 0x46, reg 0x45, reg 0x44}, with 0x44 as the least significant byte.
- R6: `nmi_vec_en` follows bit 6 of register 0x4B.
- R7: After hardware reset: register 0x40 = 0x01, 0x43 = 0x30, 0x48 = 0x01, all other registers and direct ports are 0, the index is 0 and the access flag is clear.
- R8: Port 0x72 stores the written byte ANDed with 0x7E. Ports 0x7E and 0x7F store the full byte. All three read back at their own addresses.
- R9: A write to port 0x7F with data bit 3 set, while bit 6 of register 0x41 is set, raises `sw_reset` for exactly the one cycle after the write edge. Any other 0x7F write leaves `sw_reset` low.
- R10: On the clock edge that ends the `sw_reset` pulse, every register, direct port, the index and the access flag return to their R7 values.
- R11: `ems_cfg` equals register 0x4C. `ems_cfg_wr` is high for exactly the one cycle after each accepted data write to index 0x4C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the cycle of io_rd |
| nmi_vector | output | 32 | Replacement NMI vector |
| nmi_vec_en | output | 1 | Replacement vector enable |
| ems_cfg | output | 8 | Expanded-memory configuration byte |
| ems_cfg_wr | output | 1 | One-cycle pulse after a write to ems_cfg |
| sw_reset | output | 1 | One-cycle software reset request |

## Verification
The hardest state to reach is the software reset. It needs register 0x41 bit 6 to be set first through the masked data path, and a 0x7F write with bit 3 set. The stimulus also makes the same 0x7F write with the enable clear, to show that it is ignored. It then loads nonzero NMI bytes and a non-default index before it fires the reset. The outputs are sampled on the pulse cycle and on the next cycle, and the indexed and direct registers are then read back to confirm that every field, including the index port, returned to its default. The one-access-per-index rule is exercised with a second data write and a second data read that follow an index write without a new one.

// File: rtl/cfgrf_pkg.sv
package cfgrf_pkg;

   // Bank geometry
   localparam logic [7:0] BANK_BASE  = 8'h40;
   localparam int         BANK_SLOTS = 13;

   // Slot offsets that feed outputs
   localparam int SLOT_SYS    = 1;   // holds the soft-reset enable
   localparam int SLOT_NMI0   = 4;
   localparam int SLOT_NMIEN  = 11;
   localparam int SLOT_EMS    = 12;
   localparam int NMIEN_BIT   = 6;
   localparam int SRST_EN_BIT = 6;
   localparam int SRST_GO_BIT = 3;

   localparam logic [7:0] CTL_A_MASK = 8'h7E;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_INDEX,
      SEL_DATA,
      SEL_CTL_A,
      SEL_SCRATCH,
      SEL_RESET
   } port_sel_e;

   function automatic logic slot_present(input int s);
      return (s != 10);
   endfunction

   function automatic logic [7:0] slot_mask(input int s);
      case (s)
         0:       return 8'hC7;
         1:       return 8'hED;
         2:       return 8'h01;
         default: return 8'hFF;
      endcase
   endfunction

   function automatic logic [7:0] slot_default(input int s);
      case (s)
         0:       return 8'h01;
         3:       return 8'h30;
         8:       return 8'h01;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/cfg_index_ctrl.sv
module cfg_index_ctrl (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       idx_wr,
   input  logic       data_acc,
   input  logic [7:0] wdata,
   output logic [7:0] index,
   output logic       access
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         index  <= '0;
         access <= 1'b0;
      end else if (clr) begin
         index  <= '0;
         access <= 1'b0;
      end else if (idx_wr) begin
         index  <= wdata;
         access <= 1'b1;
      end else if (data_acc) begin
         access <= 1'b0;
      end
   end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
   parameter logic [7:0] BASE  = cfgrf_pkg::BANK_BASE,
   parameter int         SLOTS = cfgrf_pkg::BANK_SLOTS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  wr_en,
   input  logic [7:0]            index,
   input  logic [7:0]            wdata,
   output logic                  hit,
   output logic [7:0]            rdata,
   output logic [SLOTS-1:0]      slot_we,
   output logic [SLOTS-1:0][7:0] regs_o
);
   import cfgrf_pkg::*;

   if (SLOTS < 1 || (int'(BASE) + SLOTS) > 256) begin : g_bad_geom
      $error("cfg_reg_bank: slot range leaves the index space");
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      if (slot_present(s)) begin : g_reg
         logic [7:0] q;
         assign slot_we[s] = wr_en && (index == BASE + 8'(s));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          q <= slot_default(s);
            else if (clr)        q <= slot_default(s);
            else if (slot_we[s]) q <= wdata & slot_mask(s);
         end
         assign regs_o[s] = q;
      end else begin : g_hole
         assign slot_we[s] = 1'b0;
         assign regs_o[s]  = '0;
      end
   end

   always_comb begin
      hit   = 1'b0;
      rdata = 8'hFF;
      for (int s = 0; s < SLOTS; s++) begin
         if (slot_present(s) && index == BASE + 8'(s)) begin
            hit   = 1'b1;
            rdata = regs_o[s];
         end
      end
   end

endmodule

// File: rtl/cfg_direct_ports.sv
module cfg_direct_ports (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we_ctl_a,
   input  logic       we_scratch,
   input  logic       we_reset,
   input  logic [7:0] wdata,
   input  logic       srst_enable,
   output logic [7:0] ctl_a,
   output logic [7:0] scratch,
   output logic [7:0] reset_ctl,
   output logic       sw_reset
);
   import cfgrf_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_a     <= '0;
         scratch   <= '0;
         reset_ctl <= '0;
         sw_reset  <= 1'b0;
      end else if (sw_reset) begin
         ctl_a     <= '0;
         scratch   <= '0;
         reset_ctl <= '0;
         sw_reset  <= 1'b0;
      end else begin
         if (we_ctl_a)   ctl_a     <= wdata & CTL_A_MASK;
         if (we_scratch) scratch   <= wdata;
         if (we_reset)   reset_ctl <= wdata;
         sw_reset <= we_reset && wdata[SRST_GO_BIT] && srst_enable;
      end
   end

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
   parameter int                ADDR_W        = 16,
   parameter logic [ADDR_W-1:0] INDEX_PORT    = ADDR_W'(16'h0022),
   parameter logic [ADDR_W-1:0] DATA_PORT     = ADDR_W'(16'h0023),
   parameter logic [ADDR_W-1:0] CTL_A_PORT   = ADDR_W'(16'h0072),
   parameter logic [ADDR_W-1:0] SCRATCH_PORT = ADDR_W'(16'h007E),
   parameter logic [ADDR_W-1:0] RESET_PORT   = ADDR_W'(16'h007F)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   output logic [31:0]       nmi_vector,
   output logic              nmi_vec_en,
   output logic [7:0]        ems_cfg,
   output logic              ems_cfg_wr,
   output logic              sw_reset
);
   import cfgrf_pkg::*;

   localparam int SLOTS = BANK_SLOTS;

   if (ADDR_W < 8) begin : g_bad_width
      $error("cfg_regfile: ADDR_W must be at least 8");
   end
   if (INDEX_PORT == DATA_PORT) begin : g_bad_ports
      $error("cfg_regfile: index and data ports must differ");
   end

   port_sel_e             sel;
   logic [7:0]            index;
   logic                  access_flag;
   logic                  bank_hit;
   logic [7:0]            bank_rdata;
   logic [SLOTS-1:0]      slot_we;
   logic [SLOTS-1:0][7:0] regs;
   logic [7:0]            ctl_a, scratch, reset_ctl;
   logic                  data_acc;

   always_comb begin
      if      (io_addr == INDEX_PORT)   sel = SEL_INDEX;
      else if (io_addr == DATA_PORT)    sel = SEL_DATA;
      else if (io_addr == CTL_A_PORT)   sel = SEL_CTL_A;
      else if (io_addr == SCRATCH_PORT) sel = SEL_SCRATCH;
      else if (io_addr == RESET_PORT)   sel = SEL_RESET;
      else                              sel = SEL_NONE;
   end

   assign data_acc = (io_wr || io_rd) && (sel == SEL_DATA);

   cfg_index_ctrl u_index (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (sw_reset),
      .idx_wr   (io_wr && sel == SEL_INDEX),
      .data_acc (data_acc),
      .wdata    (io_wdata),
      .index    (index),
      .access   (access_flag)
   );

   cfg_reg_bank #(.BASE(BANK_BASE), .SLOTS(SLOTS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (sw_reset),
      .wr_en   (io_wr && sel == SEL_DATA && access_flag),
      .index   (index),
      .wdata   (io_wdata),
      .hit     (bank_hit),
      .rdata   (bank_rdata),
      .slot_we (slot_we),
      .regs_o  (regs)
   );

   cfg_direct_ports u_direct (
      .clk         (clk),
      .rst_n       (rst_n),
      .we_ctl_a    (io_wr && sel == SEL_CTL_A),
      .we_scratch  (io_wr && sel == SEL_SCRATCH),
      .we_reset    (io_wr && sel == SEL_RESET),
      .wdata       (io_wdata),
      .srst_enable (regs[SLOT_SYS][SRST_EN_BIT]),
      .ctl_a       (ctl_a),
      .scratch     (scratch),
      .reset_ctl   (reset_ctl),
      .sw_reset    (sw_reset)
   );

   // Strobe marking a committed expanded-memory configuration write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ems_cfg_wr <= 1'b0;
      else if (sw_reset) ems_cfg_wr <= 1'b0;
      else               ems_cfg_wr <= slot_we[SLOT_EMS];
   end

   for (genvar b = 0; b < 4; b++) begin : g_nmi_byte
      assign nmi_vector[8*b +: 8] = regs[SLOT_NMI0 + b];
   end
   assign nmi_vec_en = regs[SLOT_NMIEN][NMIEN_BIT];
   assign ems_cfg    = regs[SLOT_EMS];

   always_comb begin
      io_rdata = 8'hFF;
      if (io_rd) begin
         case (sel)
            SEL_INDEX:   io_rdata = index;
            SEL_DATA:    io_rdata = (access_flag && bank_hit) ? bank_rdata : 8'hFF;
            SEL_CTL_A:   io_rdata = ctl_a;
            SEL_SCRATCH: io_rdata = scratch;
            SEL_RESET:   io_rdata = reset_ctl;
            default:     io_rdata = 8'hFF;
         endcase
      end
   end

   logic unused_bank;
   assign unused_bank = ^{slot_we[SLOTS-1], slot_we[SLOT_EMS-1:0]};

endmodule

// File: rtl/cfg_regfile_chk.sv
module cfg_regfile_chk #(
   parameter int                ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] INDEX_PORT = ADDR_W'(16'h0022),
   parameter logic [ADDR_W-1:0] DATA_PORT  = ADDR_W'(16'h0023),
   parameter logic [ADDR_W-1:0] RESET_PORT = ADDR_W'(16'h007F)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_wr,
   input logic              io_rd,
   input logic [7:0]        io_wdata,
   input logic [7:0]        io_rdata,
   input logic              access_flag,
   input logic [31:0]       nmi_vector,
   input logic              nmi_vec_en,
   input logic [7:0]        ems_cfg,
   input logic              ems_cfg_wr,
   input logic              sw_reset
);

   p_flag_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == INDEX_PORT && !sw_reset) |=> access_flag);

   p_noflag_ff_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_addr == DATA_PORT && !access_flag) |-> io_rdata == 8'hFF);

   p_flag_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((io_rd || io_wr) && io_addr == DATA_PORT) |=> !access_flag);

   p_nmi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(nmi_vector) |-> ($past(io_wr) || $past(sw_reset)));

   p_swrst_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sw_reset |=> !sw_reset);

   p_swrst_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sw_reset |-> $past(io_wr && io_addr == RESET_PORT && io_wdata[3]));

   p_defaults_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sw_reset |=> (nmi_vector == 32'h0 && !nmi_vec_en && ems_cfg == 8'h00
                    && !access_flag));

   p_ems_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ems_cfg) |-> (ems_cfg_wr || $past(sw_reset)));

   p_strobe_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ems_cfg_wr |=> !ems_cfg_wr);

endmodule

bind cfg_regfile cfg_regfile_chk #(
   .ADDR_W     (ADDR_W),
   .INDEX_PORT (INDEX_PORT),
   .DATA_PORT  (DATA_PORT),
   .RESET_PORT (RESET_PORT)
) u_chk (.*);

// File: tb/cfg_regfile_test.sv
module cfg_regfile_test;

   localparam logic [15:0] P_IDX = 16'h0022;
   localparam logic [15:0] P_DAT = 16'h0023;
   localparam logic [15:0] P_72  = 16'h0072;
   localparam logic [15:0] P_7E  = 16'h007E;
   localparam logic [15:0] P_7F  = 16'h007F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0, io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic [31:0] nmi_vector;
   logic        nmi_vec_en, ems_cfg_wr, sw_reset;
   logic [7:0]  ems_cfg;

   int vectors = 0;
   int fails   = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #2 clk = ~clk;

   cfg_regfile uut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .nmi_vector(nmi_vector),
      .nmi_vec_en(nmi_vec_en), .ems_cfg(ems_cfg), .ems_cfg_wr(ems_cfg_wr),
      .sw_reset(sw_reset)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   // Monitor: compares read data against the scoreboard queue
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (io_rd) begin
            if (exp_q.size() == 0) begin
               vectors++; fails++;
               $display("FAIL monitor: unexpected read, actual %02h expected none", io_rdata);
            end else begin
               logic [7:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(t, {24'h0, io_rdata}, {24'h0, e});
            end
         end
      end
   end

   task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      exp_q.push_back(exp); tag_q.push_back(tag);
      io_addr = a; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic wr_reg(input logic [7:0] i, input logic [7:0] d);
      bus_wr(P_IDX, i);
      bus_wr(P_DAT, d);
   endtask

   task automatic rd_reg(input logic [7:0] i, input logic [7:0] exp, input string tag);
      bus_wr(P_IDX, i);
      bus_rd(P_DAT, exp, tag);
   endtask

   bit done = 0;
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         vectors++; fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R7 reset state
      check("R7 nmi_vector", nmi_vector, 0);
      check("R7 nmi_vec_en", {31'h0, nmi_vec_en}, 0);
      check("R7 ems_cfg", {24'h0, ems_cfg}, 0);
      check("R7 sw_reset", {31'h0, sw_reset}, 0);
      bus_rd(P_IDX, 8'h00, "R7 index");
      bus_rd(P_DAT, 8'hFF, "R7/R2 flag clear");
      rd_reg(8'h40, 8'h01, "R7 reg40");
      rd_reg(8'h43, 8'h30, "R7 reg43");
      rd_reg(8'h48, 8'h01, "R7 reg48");
      rd_reg(8'h42, 8'h00, "R7 reg42");
      bus_rd(P_7F, 8'h00, "R7 port7F");

      // R3 masks
      wr_reg(8'h40, 8'hFF); rd_reg(8'h40, 8'hC7, "R3 mask40");
      wr_reg(8'h41, 8'hFF); rd_reg(8'h41, 8'hED, "R3 mask41");
      wr_reg(8'h42, 8'hFF); rd_reg(8'h42, 8'h01, "R3 mask42");
      wr_reg(8'h43, 8'hA5); rd_reg(8'h43, 8'hA5, "R3 full43");
      wr_reg(8'h49, 8'h3C); rd_reg(8'h49, 8'h3C, "R3 full49");

      // R1 index readback
      bus_wr(P_IDX, 8'h9D);
      bus_rd(P_IDX, 8'h9D, "R1 index readback");

      // R2 one access per index write
      wr_reg(8'h43, 8'h5A);
      bus_wr(P_DAT, 8'h77);
      rd_reg(8'h43, 8'h5A, "R2 second write ignored");
      bus_rd(P_DAT, 8'hFF, "R2 second read FF");

      // R4 holes
      wr_reg(8'h4A, 8'h12); rd_reg(8'h4A, 8'hFF, "R4 idx4A");
      wr_reg(8'h50, 8'h34); rd_reg(8'h50, 8'hFF, "R4 idx50");
      rd_reg(8'h49, 8'h3C, "R4 neighbour untouched");

      // R5/R6 NMI vector
      wr_reg(8'h44, 8'h11); wr_reg(8'h45, 8'h22);
      wr_reg(8'h46, 8'h33); wr_reg(8'h47, 8'h44);
      check("R5 nmi_vector", nmi_vector, 32'h44332211);
      wr_reg(8'h4B, 8'h40);
      check("R6 en set", {31'h0, nmi_vec_en}, 1);
      wr_reg(8'h4B, 8'hBF);
      check("R6 en clear", {31'h0, nmi_vec_en}, 0);

      // R11 ems strobe
      wr_reg(8'h4C, 8'h5B);
      check("R11 strobe", {31'h0, ems_cfg_wr}, 1);
      check("R11 ems_cfg", {24'h0, ems_cfg}, 8'h5B);
      @(negedge clk);
      check("R11 strobe single", {31'h0, ems_cfg_wr}, 0);
      rd_reg(8'h4C, 8'h5B, "R11 readback");

      // R8 direct ports
      bus_wr(P_72, 8'hFF); bus_rd(P_72, 8'h7E, "R8 port72");
      bus_wr(P_7E, 8'hA1); bus_rd(P_7E, 8'hA1, "R8 port7E");
      bus_wr(P_7F, 8'h04);
      check("R9 no go bit", {31'h0, sw_reset}, 0);
      bus_rd(P_7F, 8'h04, "R8 port7F");

      // R9 enable clear: ignored
      wr_reg(8'h41, 8'h00);
      bus_wr(P_7F, 8'h08);
      check("R9 disabled", {31'h0, sw_reset}, 0);
      bus_rd(P_7F, 8'h08, "R9 no reset happened");

      // R9/R10 software reset
      wr_reg(8'h41, 8'h40);
      wr_reg(8'h44, 8'h99);
      bus_wr(P_IDX, 8'h47);
      bus_wr(P_7F, 8'h0F);
      check("R9 pulse", {31'h0, sw_reset}, 1);
      @(negedge clk);
      check("R9 pulse ends", {31'h0, sw_reset}, 0);
      check("R10 nmi_vector", nmi_vector, 0);
      check("R10 ems_cfg", {24'h0, ems_cfg}, 0);
      bus_rd(P_IDX, 8'h00, "R10 index");
      bus_rd(P_DAT, 8'hFF, "R10 flag");
      bus_rd(P_7F, 8'h00, "R10 port7F");
      bus_rd(P_72, 8'h00, "R10 port72");
      rd_reg(8'h40, 8'h01, "R10 reg40");
      rd_reg(8'h41, 8'h00, "R10 reg41");
      rd_reg(8'h43, 8'h30, "R10 reg43");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         vectors++; fails++;
         $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule